// File: doc/BRIEF.md
# Two-Stage Slow Clock Divider

This block turns a fast board clock (25 MHz by default) into slow clocks for lab-speed sequential logic. The first stage is a short synchronous counter that divides by `PRE_DIV`. Its registered output is a prescaled clock of about 1 MHz.

The second stage is a chain of toggle flip-flops in ripple form. Each flip-flop is clocked by the falling edge of the one before it. The bits of the long count therefore change one after another rather than together on one clock edge, which avoids a large simultaneous switching pulse. A tap-select input picks which ripple stage drives the slow clock output. With the defaults, tap 12 gives about 122 Hz and tap 13 about 61 Hz.

Top module: `slowclk_divider`

## Requirements
- R1: After reset, `pre_clk_o` repeats every `PRE_DIV` input cycles. In each period it is high for `PRE_HIGH` cycles and low for the remaining `PRE_DIV-PRE_HIGH` cycles (defaults 25, 12 and 13).
- R2: Ripple stage k toggles once on every falling edge of stage k-1, and stage 0 toggles on every falling edge of `pre_clk_o`. Stage k therefore has a period of `PRE_DIV*2^(k+1)` input cycles.
- R3: A ripple stage changes only at the moment its predecessor falls. With tap 0 selected, every change of `slow_clk_o` falls in the same input cycle as a falling edge of `pre_clk_o`.
- R4: A `tap_sel_i` value k with k < `STAGES` routes ripple stage k to `slow_clk_o`. The route is combinational, with no extra register.
- R5: A `tap_sel_i` value of `STAGES` or more routes stage `DEFAULT_TAP` to `slow_clk_o` (default 12).
- R6: Reset behaviour:
  - An input clock edge that samples `rst_i` high clears the prescaler and every ripple stage, so both outputs are low after that edge.
  - After release, `pre_clk_o` first rises on the first edge that samples `rst_i` low (cycle 1).
  - Stage k first rises in cycle `PRE_HIGH+1+PRE_DIV*(2^k-1)`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Active-high reset, sampled on `clk_i` |
| tap_sel_i | input | TAP_W | Ripple stage that drives `slow_clk_o` |
| pre_clk_o | output | 1 | Prescaled clock, registered on `clk_i` |
| slow_clk_o | output | 1 | Selected ripple stage |

## Verification
Cycles are counted from the first edge that samples reset low. `pre_clk_o` is due high in cycle 1 and low in cycle `PRE_HIGH+1`. Stage k first rises in cycle `PRE_HIGH+1+PRE_DIV*(2^k-1)`, and rises again every `PRE_DIV*2^(k+1)` cycles after that. The monitor samples both outputs one nanosecond after each rising edge of the input clock and measures rise-to-rise distances in those cycles. Because the tap multiplexer switches at once and may produce a partial pulse, the monitor discards the first slow-clock rise after every tap change. It compares only full periods against the queued expected values.

// File: rtl/slowclk_pkg.sv
package slowclk_pkg;
    // Default build: 25 MHz in, 1 MHz prescaled, 14 ripple stages.
    localparam int DEF_PRE_DIV  = 25;
    localparam int DEF_PRE_HIGH = 12;
    localparam int DEF_STAGES   = 14;
    localparam int DEF_TAP_W    = 4;
    localparam int DEF_TAP      = 12;
endpackage

// File: rtl/slowclk_prescaler.sv
module slowclk_prescaler #(
    parameter int PRE_DIV  = slowclk_pkg::DEF_PRE_DIV,
    parameter int PRE_HIGH = slowclk_pkg::DEF_PRE_HIGH
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic pre_clk_o
);
    localparam int CNT_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(PRE_DIV - 1);
    localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(PRE_HIGH);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             clk_out;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == LAST) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        // Output is a register: high while the previous count was below HI_LIM.
        s_d.clk_out = (s_q.cnt < HI_LIM);
        if (rst_i) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        s_q <= s_d;
    end

    assign pre_clk_o = s_q.clk_out;
endmodule

// File: rtl/slowclk_toggle_stage.sv
module slowclk_toggle_stage (
    input  logic clk_fall_i,
    input  logic clr_i,
    output logic q_o
);
    logic t_d, t_q;

    always_comb begin
        t_d = ~t_q;
    end

    always_ff @(negedge clk_fall_i or posedge clr_i) begin
        if (clr_i) begin
            t_q <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign q_o = t_q;
endmodule

// File: rtl/slowclk_tap_mux.sv
module slowclk_tap_mux #(
    parameter int STAGES      = slowclk_pkg::DEF_STAGES,
    parameter int TAP_W       = slowclk_pkg::DEF_TAP_W,
    parameter int DEFAULT_TAP = slowclk_pkg::DEF_TAP
) (
    input  logic [STAGES-1:0] stages_i,
    input  logic [TAP_W-1:0]  sel_i,
    output logic              out_o
);
    always_comb begin
        out_o = stages_i[DEFAULT_TAP];
        for (int k = 0; k < STAGES; k++) begin
            if ({1'b0, sel_i} == (TAP_W+1)'(k)) begin
                out_o = stages_i[k];
            end
        end
    end
endmodule

// File: rtl/slowclk_divider.sv
module slowclk_divider #(
    parameter int PRE_DIV     = slowclk_pkg::DEF_PRE_DIV,
    parameter int PRE_HIGH    = slowclk_pkg::DEF_PRE_HIGH,
    parameter int STAGES      = slowclk_pkg::DEF_STAGES,
    parameter int TAP_W       = slowclk_pkg::DEF_TAP_W,
    parameter int DEFAULT_TAP = slowclk_pkg::DEF_TAP
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [TAP_W-1:0] tap_sel_i,
    output logic             pre_clk_o,
    output logic             slow_clk_o
);
    logic              rst_d, rst_q;
    logic              pre_clk;
    logic [STAGES-1:0] stage_q;

    // Registered copy of reset drives the ripple clears.
    always_comb begin
        rst_d = rst_i;
    end

    always_ff @(posedge clk_i) begin
        rst_q <= rst_d;
    end

    slowclk_prescaler #(
        .PRE_DIV  (PRE_DIV),
        .PRE_HIGH (PRE_HIGH)
    ) u_pre (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .pre_clk_o (pre_clk)
    );

    for (genvar k = 0; k < STAGES; k++) begin : g_ripple
        if (k == 0) begin : g_first
            slowclk_toggle_stage u_tff (
                .clk_fall_i (pre_clk),
                .clr_i      (rst_q),
                .q_o        (stage_q[0])
            );
        end else begin : g_next
            slowclk_toggle_stage u_tff (
                .clk_fall_i (stage_q[k-1]),
                .clr_i      (rst_q),
                .q_o        (stage_q[k])
            );
        end
    end

    slowclk_tap_mux #(
        .STAGES      (STAGES),
        .TAP_W       (TAP_W),
        .DEFAULT_TAP (DEFAULT_TAP)
    ) u_mux (
        .stages_i (stage_q),
        .sel_i    (tap_sel_i),
        .out_o    (slow_clk_o)
    );

    assign pre_clk_o = pre_clk;
endmodule

// File: rtl/slowclk_divider_chk.sv
module slowclk_divider_chk #(
    parameter int PRE_DIV  = slowclk_pkg::DEF_PRE_DIV,
    parameter int PRE_HIGH = slowclk_pkg::DEF_PRE_HIGH,
    parameter int STAGES   = slowclk_pkg::DEF_STAGES
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              pre_clk_o,
    input logic [STAGES-1:0] stage_q
);
    localparam int RUN_W = $clog2(PRE_DIV) + 1;

    logic [RUN_W-1:0] hi_run, lo_run;
    logic             seen_fall;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hi_run    <= '0;
            lo_run    <= '0;
            seen_fall <= 1'b0;
        end else begin
            if (pre_clk_o) begin
                hi_run <= hi_run + 1'b1;
                lo_run <= '0;
            end else begin
                lo_run <= lo_run + 1'b1;
                hi_run <= '0;
            end
            if (!pre_clk_o && hi_run != '0) begin
                seen_fall <= 1'b1;
            end
        end
    end

    a_r1_high_time: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pre_clk_o) |-> (hi_run == RUN_W'(PRE_HIGH)));

    a_r1_low_time: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(pre_clk_o) && seen_fall) |-> (lo_run == RUN_W'(PRE_DIV - PRE_HIGH)));

    a_r2_stage0_on_pre_fall: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(stage_q[0]) && !$past(rst_i)) |-> $fell(pre_clk_o));

    a_r6_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (!pre_clk_o && stage_q == '0));

    // R3: when a stage moves, its predecessor is already low.
    for (genvar k = 0; k < STAGES; k++) begin : g_order
        if (k == 0) begin : g_first
            always @(stage_q[0]) begin
                if (rst_i === 1'b0) begin
                    a_r3_after_pred_fall: assert (pre_clk_o == 1'b0);
                end
            end
        end else begin : g_next
            always @(stage_q[k]) begin
                if (rst_i === 1'b0) begin
                    a_r3_after_pred_fall: assert (stage_q[k-1] == 1'b0);
                end
            end
        end
    end
endmodule

bind slowclk_divider slowclk_divider_chk #(
    .PRE_DIV  (PRE_DIV),
    .PRE_HIGH (PRE_HIGH),
    .STAGES   (STAGES)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .pre_clk_o (pre_clk_o),
    .stage_q   (stage_q)
);

// File: tb/test_slowclk_divider.sv
module test_slowclk_divider;
    localparam int PRE_DIV     = 5;
    localparam int PRE_HIGH    = 2;
    localparam int STAGES      = 6;
    localparam int TAP_W       = 4;
    localparam int DEFAULT_TAP = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [TAP_W-1:0] tap_sel = TAP_W'(2);
    logic             pre_clk, slow_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    slowclk_divider #(
        .PRE_DIV     (PRE_DIV),
        .PRE_HIGH    (PRE_HIGH),
        .STAGES      (STAGES),
        .TAP_W       (TAP_W),
        .DEFAULT_TAP (DEFAULT_TAP)
    ) i_slowclk_divider (
        .clk_i      (clk),
        .rst_i      (rst),
        .tap_sel_i  (tap_sel),
        .pre_clk_o  (pre_clk),
        .slow_clk_o (slow_clk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Scoreboard state
    int    exp_q[$];
    string cur_req = "R2";
    bit    skip = 1'b0;
    bit    r3_on = 1'b0;
    int    r3_cnt = 0;

    // Monitor: sample 1 ns after each rising edge
    int cyc = 0;
    bit pre_prev = 1'b0, slow_prev = 1'b0;
    bit pre_seen = 1'b0, slow_seen = 1'b0, have_last = 1'b0;
    int last_pre_rise = 0, last_slow = 0, pre_chk = 0, first_slow_cyc = -1;

    always @(posedge clk) begin
        #1;
        if (rst) begin
            cyc = 0; pre_prev = 1'b0; slow_prev = 1'b0;
            pre_seen = 1'b0; have_last = 1'b0; pre_chk = 0;
        end else begin
            cyc++;
            if (pre_clk && !pre_prev) begin
                if (!pre_seen) begin
                    check(cyc == 1, "R6 first pre rise", cyc, 1);
                end else if (pre_chk < 4) begin
                    check(cyc - last_pre_rise == PRE_DIV, "R1 pre period",
                          cyc - last_pre_rise, PRE_DIV);
                end
                pre_seen = 1'b1;
                last_pre_rise = cyc;
            end
            if (!pre_clk && pre_prev && pre_chk < 4) begin
                check(cyc - last_pre_rise == PRE_HIGH, "R1 pre high time",
                      cyc - last_pre_rise, PRE_HIGH);
                pre_chk++;
            end
            if (r3_on && !skip && r3_cnt < 6 && slow_clk != slow_prev) begin
                check(pre_prev && !pre_clk, "R3 change on pre fall",
                      {pre_prev, pre_clk}, 2);
                r3_cnt++;
            end
            if (slow_clk && !slow_prev) begin
                if (!slow_seen) begin
                    first_slow_cyc = cyc;
                    slow_seen = 1'b1;
                end
                if (skip) begin
                    skip = 1'b0;
                    have_last = 1'b0;
                end else begin
                    if (have_last && exp_q.size() > 0) begin
                        int e;
                        e = exp_q.pop_front();
                        check(cyc - last_slow == e, cur_req, cyc - last_slow, e);
                    end
                    have_last = 1'b1;
                    last_slow = cyc;
                end
            end
            pre_prev = pre_clk;
            slow_prev = slow_clk;
        end
    end

    task automatic wait_drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 6000) begin
            @(negedge clk);
            n++;
        end
        if (exp_q.size() != 0) begin
            check(1'b0, {cur_req, " timeout"}, exp_q.size(), 0);
            exp_q.delete();
        end
    endtask

    // Driver: select a tap, queue the periods it must produce
    task automatic drive_tap(input int tap, input int stage, input string req);
        @(negedge clk);
        cur_req = req;
        tap_sel = TAP_W'(tap);
        skip = 1'b1;
        exp_q.push_back(PRE_DIV << (stage + 1));
        exp_q.push_back(PRE_DIV << (stage + 1));
        wait_drain();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(pre_clk == 1'b0, "R6 pre low in reset", pre_clk, 0);
        check(slow_clk == 1'b0, "R6 slow low in reset", slow_clk, 0);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        // tap 2 first rise: PRE_HIGH+1+PRE_DIV*(4-1) = 18
        check(first_slow_cyc == PRE_HIGH + 1 + PRE_DIV * 3, "R6 first slow rise",
              first_slow_cyc, PRE_HIGH + 1 + PRE_DIV * 3);
        for (int k = 0; k < STAGES; k++) begin
            drive_tap(k, k, (k == 0) ? "R2 R4 tap0" : "R2 R4 tap period");
        end
        drive_tap(9, DEFAULT_TAP, "R5 out-of-range tap 9");
        drive_tap(15, DEFAULT_TAP, "R5 out-of-range tap 15");
        // R3 phase on tap 0
        @(negedge clk);
        tap_sel = '0;
        skip = 1'b1;
        r3_on = 1'b1;
        repeat (40) @(negedge clk);
        r3_on = 1'b0;
        check(r3_cnt >= 4, "R3 change count", r3_cnt, 4);
        // Reset mid-run
        tap_sel = TAP_W'(5);
        rst = 1'b1;
        @(negedge clk);
        check(pre_clk == 1'b0, "R6 pre cleared", pre_clk, 0);
        check(slow_clk == 1'b0, "R6 slow cleared", slow_clk, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(slow_clk == 1'b0, "R6 slow low after release", slow_clk, 0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule